// File: doc/BRIEF.md
# Edge-Latched Interrupt Flag Controller

This block gathers a set of active-low external interrupt pins and one internal converter-completion pulse. It turns each qualified event into a sticky flag, masks the flags with per-vector enable bits and offers a single prioritized interrupt request to a processor core. Each pin is synchronized and then has to stay low for a minimum number of clock cycles before its falling edge counts. Shorter glitches are thrown away. Once a flag is set, it stays set after the pin returns high, so a brief event is not lost.

The request leaves the block as a valid/ready pair. `irq_valid` rises with a vector index on `irq_vec`, and both stay frozen until the core raises `irq_ready` in the same cycle. That handshake is the acknowledge. The core holds back `irq_ready` until its current instruction retires, and that is the only back-pressure. On the handshake cycle the block drops `irq_valid` for at least one cycle and re-arbitrates afterwards. It also clears the serviced flag in hardware, unless the vector is the shared one. The highest vector index is shared by the last external pin and the converter. Its group flag and its two source sub-flags stay set until software writes 1 to them.

A small register port reads and writes the enable register and reads the flag register. Writing 1 to a flag bit clears that bit.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and enable bits read 0 and `irq_valid` is low.
- R2: A pin held low for fewer than `FILT_CYCLES` (default 5) consecutive clock samples sets no flag.
- R3: A pin held low for at least `FILT_CYCLES` samples sets its flag once, and the flag remains 1 after the pin goes high again.
- R4: Register address 0 is the enable register. Bit i enables vector i, and the register reads back what was written. A set flag raises `irq_valid` only while its enable bit is 1.
- R5: When several enabled flags are pending, `irq_vec` carries the lowest pending vector index.
- R6: While `irq_valid` is high and `irq_ready` is low, `irq_valid` stays high and `irq_vec` stays unchanged in the next cycle, even if higher-priority flags arrive.
- R7: A handshake on vector i below the shared index clears flag bit i.
- R8: The flag register is at address 1. Bits 0 to NUM_PINS-2 are the private pin flags, and bit NUM_PINS-1 is the group flag of the shared vector. Bit NUM_PINS is the shared pin's sub-flag and bit NUM_PINS+1 is the converter sub-flag. A shared-pin event or an `adc_done` pulse sets the group flag and its own sub-flag. None of these three bits is cleared by a handshake.
- R9: Writing 1 to a flag bit at address 1 clears it. Writing 0 leaves it unchanged.
- R10: When a set event and a software clear of the same flag bit happen in the same cycle, the flag ends up set.
- R11: Raising `irq_ready` while `irq_valid` is low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_int_n | input | NUM_PINS | Active-low external interrupt pins, idle high |
| adc_done | input | 1 | One-cycle converter completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 flags |
| reg_wdata | input | NUM_PINS+2 | Write data |
| reg_rdata | output | NUM_PINS+2 | Read data for `reg_addr` (combinational) |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Core acknowledge, effective only with `irq_valid` |
| irq_vec | output | $clog2(NUM_PINS) | Vector index of the request |

## Verification
The assertions assume that `irq_ready` is meaningful only when `irq_valid` is high. They also assume that `adc_done` and software writes arrive synchronous to `clk`, and that pins only need to be synchronous at the filter output. The stimulus changes every input at the falling clock edge. It drives pins as clean low pulses of a chosen length, and it only raises `irq_ready` for one cycle at a time. A vector can therefore only be acknowledged when a request is present, except in the one case that checks R11 on purpose.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic {
    REG_ENABLE = 1'b0,
    REG_FLAGS  = 1'b1
  } irq_reg_e;
endpackage

// File: rtl/irq_pin_filter.sv
// Two-flop synchronizer followed by a low-level width qualifier.
// Emits one pulse on the FILT_CYCLES-th consecutive low sample.
module irq_pin_filter #(
  parameter int FILT_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fire
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      if (sync_q[1])
        cnt_q <= '0;
      else if (cnt_q != CW'(FILT_CYCLES))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire = !sync_q[1] && (cnt_q == CW'(FILT_CYCLES - 1));
endmodule

// File: rtl/irq_state_bank.sv
// Enable register, sticky flag register and register read mux.
module irq_state_bank
  import irq_flag_pkg::*;
#(
  parameter int NUM_PINS = 3,
  parameter int VW       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_fire,
  input  logic                  adc_done,
  input  logic                  reg_wr,
  input  logic                  reg_addr,
  input  logic [NUM_PINS+1:0]   reg_wdata,
  output logic [NUM_PINS+1:0]   reg_rdata,
  input  logic                  ack_fire,
  input  logic [VW-1:0]         ack_vec,
  output logic [NUM_PINS+1:0]   flags,
  output logic [NUM_PINS+1:0]   flag_set,
  output logic [NUM_PINS-1:0]   pend
);
  localparam int REG_W = NUM_PINS + 2;
  localparam int SH    = NUM_PINS - 1;
  localparam int SUB_P = NUM_PINS;
  localparam int SUB_C = NUM_PINS + 1;

  logic [NUM_PINS-1:0] en_q;
  logic [REG_W-1:0]    flag_q;
  logic [REG_W-1:0]    sw_clr;
  logic [REG_W-1:0]    hw_clr;

  always_comb begin
    flag_set = '0;
    for (int i = 0; i < SH; i++) flag_set[i] = pin_fire[i];
    flag_set[SH]    = pin_fire[SH] | adc_done;
    flag_set[SUB_P] = pin_fire[SH];
    flag_set[SUB_C] = adc_done;
  end

  assign sw_clr = (reg_wr && reg_addr == REG_FLAGS) ? reg_wdata : '0;

  always_comb begin
    hw_clr = '0;
    if (ack_fire && ack_vec != VW'(SH))
      hw_clr[ack_vec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (reg_wr && reg_addr == REG_ENABLE)
        en_q <= reg_wdata[NUM_PINS-1:0];
      flag_q <= (flag_q & ~(sw_clr | hw_clr)) | flag_set;
    end
  end

  assign flags     = flag_q;
  assign pend      = flag_q[NUM_PINS-1:0] & en_q;
  assign reg_rdata = (reg_addr == REG_FLAGS) ? flag_q : REG_W'(en_q);
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority pick (lowest index) with a held valid/ready request.
module irq_arbiter #(
  parameter int NUM_VEC = 3,
  parameter int VW      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] pend,
  input  logic               ready,
  output logic               valid,
  output logic [VW-1:0]      vec
);
  logic [VW-1:0] win;

  always_comb begin
    win = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--)
      if (pend[i]) win = VW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vec   <= '0;
    end else if (valid) begin
      if (ready) valid <= 1'b0;
    end else if (|pend) begin
      valid <= 1'b1;
      vec   <= win;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int NUM_PINS    = 3,
  parameter int FILT_CYCLES = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PINS-1:0]           ext_int_n,
  input  logic                          adc_done,
  input  logic                          reg_wr,
  input  logic                          reg_addr,
  input  logic [NUM_PINS+1:0]           reg_wdata,
  output logic [NUM_PINS+1:0]           reg_rdata,
  output logic                          irq_valid,
  input  logic                          irq_ready,
  output logic [$clog2(NUM_PINS)-1:0]   irq_vec
);
  localparam int VW = $clog2(NUM_PINS);

  logic [NUM_PINS-1:0] pin_fire;
  logic [NUM_PINS+1:0] flags;
  logic [NUM_PINS+1:0] flag_set;
  logic [NUM_PINS-1:0] pend;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_n(ext_int_n[g]),
      .fire (pin_fire[g])
    );
  end

  irq_state_bank #(.NUM_PINS(NUM_PINS), .VW(VW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_fire (pin_fire),
    .adc_done (adc_done),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ack_fire (irq_valid && irq_ready),
    .ack_vec  (irq_vec),
    .flags    (flags),
    .flag_set (flag_set),
    .pend     (pend)
  );

  irq_arbiter #(.NUM_VEC(NUM_PINS), .VW(VW)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend),
    .ready(irq_ready),
    .valid(irq_valid),
    .vec  (irq_vec)
  );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
  import irq_flag_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        irq_valid,
  input logic                        irq_ready,
  input logic [$clog2(NUM_PINS)-1:0] irq_vec,
  input logic [NUM_PINS-1:0]         pend,
  input logic [NUM_PINS+1:0]         flags,
  input logic [NUM_PINS+1:0]         flag_set,
  input logic                        reg_wr,
  input logic                        reg_addr,
  input logic [NUM_PINS+1:0]         reg_wdata
);
  localparam int VW    = $clog2(NUM_PINS);
  localparam int SH    = NUM_PINS - 1;
  localparam int SUB_C = NUM_PINS + 1;

  logic [NUM_PINS-1:0] pend_d;
  logic [NUM_PINS-1:0] below;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_d <= '0;
    else        pend_d <= pend;

  always_comb
    for (int i = 0; i < NUM_PINS; i++) below[i] = (VW'(i) < irq_vec);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vec));

  assert_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> pend_d[irq_vec] && ((pend_d & below) == '0));

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready && irq_vec != VW'(SH)
      |=> !flags[$past(irq_vec)] || $past(flag_set[irq_vec]));

  assert_group_sw_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[SH]) |-> $past(reg_wr && reg_addr == REG_FLAGS && reg_wdata[SH]));

  assert_conv_sw_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[SUB_C]) |-> $past(reg_wr && reg_addr == REG_FLAGS && reg_wdata[SUB_C]));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_valid(irq_valid),
  .irq_ready(irq_ready),
  .irq_vec  (irq_vec),
  .pend     (pend),
  .flags    (flags),
  .flag_set (flag_set),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  localparam int NP = 3;
  localparam int RW = NP + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] ext_int_n = '1;
  logic          adc_done = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_addr = 1'b0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          irq_valid;
  logic          irq_ready = 1'b0;
  logic [1:0]    irq_vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_flag_ctrl #(.NUM_PINS(NP), .FILT_CYCLES(5)) dut (
    .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n), .adc_done(adc_done),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vec(irq_vec)
  );

  // table: pin index, low cycles, flag expected
  localparam int TBL_N = 8;
  localparam int TBL [TBL_N][3] = '{
    '{0, 3, 0}, '{0, 4, 0}, '{0, 5, 1}, '{1, 8, 1},
    '{2, 5, 1}, '{1, 2, 0}, '{2, 4, 0}, '{0, 12, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_pins(input logic [NP-1:0] mask, input int n);
    ext_int_n = ~mask;
    repeat (n) @(negedge clk);
    ext_int_n = '1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [RW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic ack();
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b1, v); check("R1 flags", v, 0);
    rd(1'b0, v); check("R1 enable", v, 0);
    check("R1 valid", irq_valid, 0);

    // table walk: R2 short pulses rejected, R3 long pulses latched
    for (int k = 0; k < TBL_N; k++) begin
      int exp;
      pulse_pins(NP'(1 << TBL[k][0]), TBL[k][1]);
      exp = 0;
      if (TBL[k][2] != 0)
        exp = (TBL[k][0] == NP - 1) ? ((1 << (NP - 1)) | (1 << NP)) : (1 << TBL[k][0]);
      rd(1'b1, v);
      check(TBL[k][2] != 0 ? "R3 latched" : "R2 rejected", v, exp);
      wr(1'b1, '1);
    end

    // R4 enable gating
    pulse_pins(3'b010, 6);
    check("R4 masked", irq_valid, 0);
    wr(1'b0, 5'b00010);
    rd(1'b0, v); check("R4 readback", v, 2);
    repeat (3) @(negedge clk);
    check("R4 valid", irq_valid, 1);
    check("R4 vec", irq_vec, 1);

    // R6 hold against higher priority arrival
    wr(1'b0, 5'b00011);
    pulse_pins(3'b001, 6);
    check("R6 valid held", irq_valid, 1);
    check("R6 vec held", irq_vec, 1);
    ack();
    rd(1'b1, v); check("R7 auto clear", v, 1);
    check("R5 next vec", irq_vec, 0);
    check("R5 next valid", irq_valid, 1);
    ack();
    rd(1'b1, v); check("R7 clear vec0", v, 0);
    check("R7 idle", irq_valid, 0);

    // R5 simultaneous pins 1 and 2, then shared vector retention
    wr(1'b0, 5'b00111);
    pulse_pins(3'b110, 6);
    check("R5 lowest wins", irq_vec, 1);
    ack();
    check("R8 shared vec", irq_vec, 2);
    check("R8 shared valid", irq_valid, 1);
    ack();
    rd(1'b1, v); check("R8 not auto cleared", v, 5'b01100);
    check("R8 re-request", irq_valid, 1);
    wr(1'b1, 5'b11100);
    ack();
    rd(1'b1, v); check("R9 sw clear", v, 0);
    check("R9 idle", irq_valid, 0);

    // R8 converter source
    wr(1'b0, 5'b00100);
    adc_done = 1'b1; @(negedge clk); adc_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 conv valid", irq_valid, 1);
    check("R8 conv vec", irq_vec, 2);
    ack();
    rd(1'b1, v); check("R8 conv kept", v, 5'b10100);
    wr(1'b1, 5'b10100);
    ack();
    check("R8 conv idle", irq_valid, 0);

    // R10 set beats clear
    wr(1'b0, 5'b00000);
    adc_done = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 5'b10100;
    @(negedge clk);
    adc_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1'b1, v); check("R10 set wins", v, 5'b10100);
    wr(1'b1, '1);

    // R9 write of zero has no effect
    pulse_pins(3'b001, 6);
    wr(1'b1, 5'b00000);
    rd(1'b1, v); check("R9 zero write", v, 1);

    // R11 ready without valid
    ack();
    rd(1'b1, v); check("R11 stray ready", v, 1);
    wr(1'b1, '1);
    rd(1'b1, v); check("R9 final clear", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule